// File: doc/BRIEF.md
# Four-Register Bus Mini Processor

This block is a tiny processor with a control sequencer and an 8-bit datapath that share one internal bus. The datapath holds four general registers, an operand register that captures the first operand of an arithmetic operation, and a result register loaded from an adder/subtractor. The bus is a multiplexer. One-hot drive strobes select the source, and it reads zero when nothing drives it.

An instruction starts when the start strobe is high while the sequencer is in its idle step. In that cycle the function word is captured, and the sequencer then walks through numbered steps. The step machine has four named states. IDLE (ST_T0) waits for start and moves to ST_T1 when start is high. ST_T1 moves to ST_T2, ST_T2 moves to ST_T3, and ST_T3 returns to ST_T0. Any step in which the done flag is high, and any cycle with reset high, returns to ST_T0. Load and Move therefore take ST_T0 and then ST_T1. Add and Sub use all four steps.

The surrounding logic sees the bus value and a done flag. It can read a register by issuing a Move of that register onto itself and sampling the bus in the completion cycle.

Top module: `mini_proc`

## Requirements
- R1: Synchronous reset returns the sequencer to ST_T0 and clears the captured function word. In the cycle after reset, done is low and the bus reads zero.
- R2: In ST_T0 with start low, the sequencer stays idle, raises no strobe, keeps done low, drives the bus to zero, and no register changes.
- R3: The function word is captured only in ST_T0 with start high. Bits [5:4] hold the operation (00 Load, 01 Move, 10 Add, 11 Sub), bits [3:2] the destination Rx, and bits [1:0] the source Ry. Changes on the function-word input during execution have no effect.
- R4: Load finishes in ST_T1. External data drives the bus, Rx takes it, and done is high in that cycle.
- R5: Move finishes in ST_T1. Ry drives the bus, Rx takes it, and done is high in that cycle.
- R6: Add takes three steps after ST_T0. In ST_T1 Rx drives the bus and is loaded into the operand register. In ST_T2 the result register takes the operand plus Ry. In ST_T3 the result drives the bus, is written to Rx, and done is high. The sum wraps modulo 256.
- R7: Sub follows the same sequence as Add, but the result is the operand minus Ry, wrapping modulo 256.
- R8: Done is high for exactly one cycle per instruction, only in the final step, and the next cycle is ST_T0.
- R9: At most one bus source is enabled in any cycle. With none enabled, the bus reads zero.
- R10: With Rx equal to Ry, Move leaves the register unchanged, Add doubles it, and Sub clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts an instruction when the sequencer is idle |
| func_word | input | 6 | Operation, destination and source fields |
| ext_data | input | 8 | External data for Load |
| bus_out | output | 8 | Current value of the internal bus |
| done | output | 1 | High in the final step of an instruction |

## Verification
The checker covers the properties that hold in every cycle. It confirms that at most one bus source is enabled and that an undriven bus reads zero. It also confirms that done lasts one cycle, occurs only in a valid final step, and is never raised during an arithmetic ST_T1, that the idle state holds without start, and that the captured function word stays stable outside ST_T0. Arithmetic results, register contents, same-register corner cases, the ignored function-word changes during execution, and an abort by reset mid-instruction can only be shown by the bench scenarios. The bench compares those against a register model by using Move readbacks.

// File: rtl/mp_pkg.sv
package mp_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_MOVE = 2'd1,
        OP_ADD  = 2'd2,
        OP_SUB  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_T0 = 2'd0,
        ST_T1 = 2'd1,
        ST_T2 = 2'd2,
        ST_T3 = 2'd3
    } step_e;

    localparam int OP_W = 2;

endpackage

// File: rtl/mp_sequencer.sv
module mp_sequencer
    import mp_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int FUNC_W = OP_W + 2 * SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              done,
    input  logic [FUNC_W-1:0] func_word,
    output step_e             step,
    output logic [FUNC_W-1:0] func_q,
    output op_e               op,
    output logic [SEL_W-1:0]  rx,
    output logic [SEL_W-1:0]  ry
);

    step_e step_nxt;

    // next-step logic: counts up, cleared when idle or finishing
    always_comb begin
        step_nxt = ST_T0;
        unique case (step)
            ST_T0: step_nxt = start ? ST_T1 : ST_T0;
            ST_T1: step_nxt = ST_T2;
            ST_T2: step_nxt = ST_T3;
            ST_T3: step_nxt = ST_T0;
        endcase
        if (done) begin
            step_nxt = ST_T0;
        end
    end

    // step register
    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_T0;
        end else begin
            step <= step_nxt;
        end
    end

    // function register, captured only when an instruction starts
    always_ff @(posedge clk) begin
        if (rst) begin
            func_q <= '0;
        end else if (step == ST_T0 && start) begin
            func_q <= func_word;
        end
    end

    assign op = op_e'(func_q[FUNC_W-1 -: OP_W]);
    assign rx = func_q[2*SEL_W-1 -: SEL_W];
    assign ry = func_q[SEL_W-1:0];

endmodule

// File: rtl/mp_control.sv
module mp_control
    import mp_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int SEL_W = $clog2(NREG)
) (
    input  step_e            step,
    input  op_e              op,
    input  logic [SEL_W-1:0] rx,
    input  logic [SEL_W-1:0] ry,
    output logic [NREG-1:0]  reg_load,
    output logic [NREG-1:0]  reg_drive,
    output logic             a_load,
    output logic             g_load,
    output logic             g_drive,
    output logic             ext_drive,
    output logic             sub_sel,
    output logic             done
);

    logic [NREG-1:0] rx_hot;
    logic [NREG-1:0] ry_hot;

    // one-hot register selects
    always_comb begin
        rx_hot = '0;
        ry_hot = '0;
        rx_hot[rx] = 1'b1;
        ry_hot[ry] = 1'b1;
    end

    // strobes per step and operation; everything inactive by default
    always_comb begin
        reg_load  = '0;
        reg_drive = '0;
        a_load    = 1'b0;
        g_load    = 1'b0;
        g_drive   = 1'b0;
        ext_drive = 1'b0;
        sub_sel   = 1'b0;
        done      = 1'b0;
        unique case (step)
            ST_T0: begin
            end
            ST_T1: begin
                unique case (op)
                    OP_LOAD: begin
                        ext_drive = 1'b1;
                        reg_load  = rx_hot;
                        done      = 1'b1;
                    end
                    OP_MOVE: begin
                        reg_drive = ry_hot;
                        reg_load  = rx_hot;
                        done      = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        reg_drive = rx_hot;
                        a_load    = 1'b1;
                    end
                endcase
            end
            ST_T2: begin
                if (op == OP_ADD || op == OP_SUB) begin
                    reg_drive = ry_hot;
                    g_load    = 1'b1;
                    sub_sel   = (op == OP_SUB);
                end
            end
            ST_T3: begin
                if (op == OP_ADD || op == OP_SUB) begin
                    g_drive  = 1'b1;
                    reg_load = rx_hot;
                    done     = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/mp_datapath.sv
module mp_datapath #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4
) (
    input  logic              clk,
    input  logic [DATA_W-1:0] ext_data,
    input  logic [NREG-1:0]   reg_load,
    input  logic [NREG-1:0]   reg_drive,
    input  logic              a_load,
    input  logic              g_load,
    input  logic              g_drive,
    input  logic              ext_drive,
    input  logic              sub_sel,
    output logic [DATA_W-1:0] bus
);

    logic [DATA_W-1:0] gpr [NREG];
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] g_q;
    logic [DATA_W-1:0] alu_out;

    // general registers, written only from the bus
    for (genvar i = 0; i < NREG; i++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (reg_load[i]) begin
                gpr[i] <= bus;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (a_load) begin
            a_q <= bus;
        end
    end

    // wrapping adder/subtractor
    assign alu_out = sub_sel ? (a_q - bus) : (a_q + bus);

    always_ff @(posedge clk) begin
        if (g_load) begin
            g_q <= alu_out;
        end
    end

    // AND-OR bus multiplexer, zero when undriven
    always_comb begin
        bus = '0;
        for (int i = 0; i < NREG; i++) begin
            bus = bus | (gpr[i] & {DATA_W{reg_drive[i]}});
        end
        bus = bus | (g_q & {DATA_W{g_drive}});
        bus = bus | (ext_data & {DATA_W{ext_drive}});
    end

endmodule

// File: rtl/mini_proc.sv
module mini_proc
    import mp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start,
    input  logic [OP_W+2*$clog2(NREG)-1:0]         func_word,
    input  logic [DATA_W-1:0]                      ext_data,
    output logic [DATA_W-1:0]                      bus_out,
    output logic                                   done
);

    localparam int SEL_W  = $clog2(NREG);
    localparam int FUNC_W = OP_W + 2 * SEL_W;

    step_e             step;
    op_e               op;
    logic [FUNC_W-1:0] func_q;
    logic [SEL_W-1:0]  rx;
    logic [SEL_W-1:0]  ry;
    logic [NREG-1:0]   reg_load;
    logic [NREG-1:0]   reg_drive;
    logic              a_load;
    logic              g_load;
    logic              g_drive;
    logic              ext_drive;
    logic              sub_sel;

    mp_sequencer #(.SEL_W(SEL_W), .FUNC_W(FUNC_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .done      (done),
        .func_word (func_word),
        .step      (step),
        .func_q    (func_q),
        .op        (op),
        .rx        (rx),
        .ry        (ry)
    );

    mp_control #(.NREG(NREG), .SEL_W(SEL_W)) u_ctl (
        .step      (step),
        .op        (op),
        .rx        (rx),
        .ry        (ry),
        .reg_load  (reg_load),
        .reg_drive (reg_drive),
        .a_load    (a_load),
        .g_load    (g_load),
        .g_drive   (g_drive),
        .ext_drive (ext_drive),
        .sub_sel   (sub_sel),
        .done      (done)
    );

    mp_datapath #(.DATA_W(DATA_W), .NREG(NREG)) u_dp (
        .clk       (clk),
        .ext_data  (ext_data),
        .reg_load  (reg_load),
        .reg_drive (reg_drive),
        .a_load    (a_load),
        .g_load    (g_load),
        .g_drive   (g_drive),
        .ext_drive (ext_drive),
        .sub_sel   (sub_sel),
        .bus       (bus_out)
    );

endmodule

// File: rtl/mp_checker.sv
module mp_checker #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    parameter int FUNC_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [1:0]        step,
    input logic [1:0]        op,
    input logic [FUNC_W-1:0] func_q,
    input logic [NREG-1:0]   reg_drive,
    input logic              g_drive,
    input logic              ext_drive,
    input logic [DATA_W-1:0] bus_out,
    input logic              done
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (step == 2'd0));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (step == 2'd0 && !start) |=> (step == 2'd0));

    a_r3_func_stable: assert property (@(posedge clk) disable iff (rst)
        (step != 2'd0) |=> $stable(func_q));

    a_r6_no_early_done: assert property (@(posedge clk) disable iff (rst)
        (step == 2'd1 && op[1]) |-> !done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && step == 2'd0));

    a_r8_done_final_step: assert property (@(posedge clk) disable iff (rst)
        done |-> ((step == 2'd1 && !op[1]) || (step == 2'd3 && op[1])));

    a_r9_onehot_src: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_drive, g_drive, ext_drive}));

    a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        ({reg_drive, g_drive, ext_drive} == '0) |-> (bus_out == '0));

endmodule

bind mini_proc mp_checker #(.DATA_W(DATA_W), .NREG(NREG), .FUNC_W(FUNC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .step      (step),
    .op        (op),
    .func_q    (func_q),
    .reg_drive (reg_drive),
    .g_drive   (g_drive),
    .ext_drive (ext_drive),
    .bus_out   (bus_out),
    .done      (done)
);

// File: tb/mini_proc_test.sv
`timescale 1ns/1ps
module mini_proc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [5:0] func_word = '0;
    logic [7:0] ext_data = '0;
    logic [7:0] bus_out;
    logic       done;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [4];

    always #2.5 clk = ~clk;

    mini_proc uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .func_word (func_word),
        .ext_data  (ext_data),
        .bus_out   (bus_out),
        .done      (done)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] calc(input logic [1:0] op, input logic [7:0] xv,
                                        input logic [7:0] yv, input logic [7:0] dv);
        case (op)
            2'd0:    return dv;
            2'd1:    return yv;
            2'd2:    return xv + yv;
            default: return xv - yv;
        endcase
    endfunction

    // opcodes: 0 Load, 1 Move, 2 Add, 3 Sub
    task automatic run(input logic [1:0] op, input logic [1:0] rx, input logic [1:0] ry,
                       input logic [7:0] dv, input string req);
        logic [7:0] exp;
        exp = calc(op, model[rx], model[ry], dv);
        @(negedge clk);
        start = 1'b1;
        func_word = {op, rx, ry};
        ext_data = dv;
        @(negedge clk);
        start = 1'b0;
        func_word = 6'($urandom);   // R3: ignored after capture
        if (op < 2'd2) begin
            check({req, " done in T1"}, {7'd0, done}, 8'd1);
            check({req, " bus in T1"}, bus_out, exp);
        end else begin
            check({req, " R6 no done T1"}, {7'd0, done}, 8'd0);
            check({req, " R6 Rx on bus T1"}, bus_out, model[rx]);
            @(negedge clk);
            ext_data = 8'($urandom);
            check({req, " R6 no done T2"}, {7'd0, done}, 8'd0);
            check({req, " R6 Ry on bus T2"}, bus_out, model[ry]);
            @(negedge clk);
            check({req, " done in T3"}, {7'd0, done}, 8'd1);
            check({req, " result in T3"}, bus_out, exp);
        end
        model[rx] = exp;
        @(negedge clk);
        check({req, " R8 done one cycle"}, {7'd0, done}, 8'd0);
        check({req, " R2 idle bus zero"}, bus_out, 8'd0);
    endtask

    task automatic readback(input string req);
        for (int k = 0; k < 4; k++) begin
            run(2'd1, 2'(k), 2'(k), 8'd0, {req, " readback R5"});
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done low after reset", {7'd0, done}, 8'd0);
        check("R1 bus zero after reset", bus_out, 8'd0);

        // R4: fill every register
        run(2'd0, 2'd0, 2'd3, 8'h11, "R4 load r0");
        run(2'd0, 2'd1, 2'd0, 8'hF0, "R4 load r1");
        run(2'd0, 2'd2, 2'd1, 8'h7F, "R4 load r2");
        run(2'd0, 2'd3, 2'd2, 8'h01, "R4 load r3");

        // R2: idle with noise on the inputs
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            func_word = 6'($urandom);
            ext_data = 8'($urandom);
            check("R2 idle done low", {7'd0, done}, 8'd0);
            check("R2 idle bus zero", bus_out, 8'd0);
        end
        readback("R2 regs unchanged");

        // directed corners
        run(2'd2, 2'd1, 2'd1, 8'd0, "R10 add same doubles wrap R6");
        run(2'd3, 2'd2, 2'd2, 8'd0, "R10 sub same clears R7");
        run(2'd1, 2'd3, 2'd3, 8'd0, "R10 move same R5");
        run(2'd3, 2'd3, 2'd0, 8'd0, "R7 sub underflow wraps");
        run(2'd2, 2'd0, 2'd1, 8'd0, "R6 add different");
        run(2'd1, 2'd2, 2'd0, 8'd0, "R5 move different");
        readback("R3 R10 after directed");

        // R1: reset in the middle of an Add
        @(negedge clk);
        start = 1'b1;
        func_word = {2'd2, 2'd1, 2'd2};
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 abort done low", {7'd0, done}, 8'd0);
        check("R1 abort bus zero", bus_out, 8'd0);
        readback("R1 abort keeps regs");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] op;
            op = 2'($urandom);
            run(op, 2'($urandom), 2'($urandom), 8'($urandom), "R3 R8 random");
        end
        readback("R9 final readback");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule